// File: doc/BRIEF.md
# Multi-Master Bus Firewall Checker

This block sits in front of one port of a shared on-chip interconnect and decides, for every incoming transaction, whether it may proceed. Each transaction carries the issuing master's ID, a non-secure attribute bit and an address. The checker compares the address against a small table of address windows. Each window names the set of masters allowed to reach it and may also demand a secure-state access. A window can therefore belong to one master, be shared by two chosen masters, or be open to every master, and any of these can be narrowed to secure-state traffic.

The window table is written through a configuration port. Only writes flagged as coming from the privileged security controller take effect. When a transaction is refused, a sticky fault record keeps the ID and address of the first offender until the security controller clears it. An open-firewall input, used during bring-up, lets every transaction through.

Top module: `bus_firewall`

## Requirements
- R1: For each cycle with `acc_valid` high, `dec_valid` is high in the next cycle and carries the decision in `dec_grant`. In a cycle after one with `acc_valid` low, `dec_valid` and `dec_grant` are low.
- R2: An enabled window matches when its base is at most the address and the address is at most its limit, with both bounds inclusive. An access that hits no enabled window is denied.
- R3: When several enabled windows match, the window with the lowest index alone decides the outcome, even when a higher window would allow the access.
- R4: Bit i of a window's 4-bit master mask admits master ID i. One set bit makes the window exclusive, two set bits share it with a pair of masters, and 4'hF opens it to all masters.
- R5: A window whose secure-only flag is set refuses accesses with `acc_ns`=1. It admits accesses with `acc_ns`=0 from masters in its mask.
- R6: While `open_mode` is high, every access is granted and the fault record is left unchanged.
- R7: A configuration write takes effect only when `cfg_we` and `cfg_priv` are both high. The `cfg_sel` field selects the action: 0 writes the base, 1 writes the limit, 2 writes the attributes, and 3 clears the fault record. The attribute word holds the mask in bits 3:0, the secure-only flag in bit 4 and the enable in bit 5. A write with `cfg_priv` low changes nothing.
- R8: A denied access sets `fault_flag` in the same cycle that `dec_valid` reports it, and latches its master ID and address. While the flag is set, later denials do not overwrite the record.
- R9: A privileged clear drops `fault_flag` one cycle later. If a denial arrives in the same cycle as the clear, the flag stays set and records the new offender.
- R10: After reset, every window is disabled, `fault_flag` is low, `fault_mid` and `fault_addr` are zero, and `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_mode | input | 1 | Grant every access while high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_mid | input | 2 | Master ID of the access |
| acc_ns | input | 1 | Non-secure attribute (1 = non-secure) |
| acc_addr | input | 32 | Access address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Write comes from the security controller |
| cfg_sel | input | 2 | 0 base, 1 limit, 2 attributes, 3 clear fault |
| cfg_idx | input | 3 | Window index for the write |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | A decision is presented |
| dec_grant | output | 1 | Decision: 1 grant, 0 deny |
| fault_flag | output | 1 | Sticky denial flag |
| fault_mid | output | 2 | Master ID of the recorded denial |
| fault_addr | output | 32 | Address of the recorded denial |

## Verification
The directed accesses target each window's exact base, its exact limit and the address just past the limit. These show whether the comparisons are inclusive. Overlapping windows whose policies disagree show whether the lowest index has priority. Every master ID is sent against an exclusive, a pair-shared and an all-master window, in both security states, which separates faults in the mask lookup from faults in the secure-only gating. Random traffic then mixes master IDs, security states, addresses inside and outside the windows, the open mode and privileged clears. The bench compares every decision and every fault record against its own table model. Unprivileged writes, and a clear that lands in the same cycle as a denial, are tested directly.

// File: rtl/fw_pkg.sv
`timescale 1ns/1ps
package fw_pkg;
  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_LIMIT = 2'd1,
    CFG_ATTR  = 2'd2,
    CFG_CLEAR = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fw_region_table.sv
`timescale 1ns/1ps
module fw_region_table #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int NUM_MASTERS = 4,
  parameter int IDX_W       = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic                                   cfg_priv,
  input  logic [1:0]                             cfg_sel,
  input  logic [IDX_W-1:0]                       cfg_idx,
  input  logic [ADDR_W-1:0]                      cfg_wdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     base_o,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     limit_o,
  output logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] mask_o,
  output logic [NUM_REGIONS-1:0]                 secure_o,
  output logic [NUM_REGIONS-1:0]                 enable_o,
  output logic                                   clear_req_o
);
  import fw_pkg::*;

  localparam int SEC_BIT = NUM_MASTERS;
  localparam int EN_BIT  = NUM_MASTERS + 1;

  logic     write_ok;
  cfg_sel_e sel;

  assign write_ok    = cfg_we & cfg_priv;
  assign sel         = cfg_sel_e'(cfg_sel);
  assign clear_req_o = write_ok && (sel == CFG_CLEAR);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic                   hit_me;
    logic [ADDR_W-1:0]      base_q;
    logic [ADDR_W-1:0]      limit_q;
    logic [NUM_MASTERS-1:0] mask_q;
    logic                   sec_q;
    logic                   en_q;

    assign hit_me = write_ok && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        mask_q  <= '0;
        sec_q   <= 1'b0;
        en_q    <= 1'b0;
      end else if (hit_me) begin
        case (sel)
          CFG_BASE:  base_q  <= cfg_wdata;
          CFG_LIMIT: limit_q <= cfg_wdata;
          CFG_ATTR: begin
            mask_q <= cfg_wdata[NUM_MASTERS-1:0];
            sec_q  <= cfg_wdata[SEC_BIT];
            en_q   <= cfg_wdata[EN_BIT];
          end
          default: ;
        endcase
      end
    end

    assign base_o[g]   = base_q;
    assign limit_o[g]  = limit_q;
    assign mask_o[g]   = mask_q;
    assign secure_o[g] = sec_q;
    assign enable_o[g] = en_q;
  end

  // R7: an unprivileged write leaves the whole table untouched
  assert_locked_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> ($stable(base_o) && $stable(limit_o) &&
                               $stable(mask_o) && $stable(secure_o) && $stable(enable_o)));
endmodule

// File: rtl/fw_match.sv
`timescale 1ns/1ps
module fw_match #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 2,
  parameter int NUM_MASTERS = 4
) (
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]      base_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]      limit_i,
  input  logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] mask_i,
  input  logic [NUM_REGIONS-1:0]                  secure_i,
  input  logic [NUM_REGIONS-1:0]                  enable_i,
  input  logic [ADDR_W-1:0]                       addr_i,
  input  logic [MID_W-1:0]                        mid_i,
  input  logic                                    ns_i,
  output logic [NUM_REGIONS-1:0]                  match_o,
  output logic                                    hit_o,
  output logic                                    allow_o,
  output logic                                    win_secure_o
);
  function automatic logic in_window(input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi,
                                     input logic [ADDR_W-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic policy_ok(input logic [NUM_MASTERS-1:0] mask,
                                     input logic [MID_W-1:0]       mid,
                                     input logic                   sec_only,
                                     input logic                   ns);
    return mask[mid] && !(sec_only && ns);
  endfunction

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign match_o[g] = enable_i[g] && in_window(base_i[g], limit_i[g], addr_i);
  end

  // scan from the top so the lowest matching index is the last writer
  always_comb begin
    hit_o        = 1'b0;
    allow_o      = 1'b0;
    win_secure_o = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match_o[i]) begin
        hit_o        = 1'b1;
        allow_o      = policy_ok(mask_i[i], mid_i, secure_i[i], ns_i);
        win_secure_o = secure_i[i];
      end
    end
  end
endmodule

// File: rtl/fw_fault_log.sv
`timescale 1ns/1ps
module fw_fault_log #(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_evt,
  input  logic [MID_W-1:0]  deny_mid,
  input  logic [ADDR_W-1:0] deny_addr,
  input  logic              clear_req,
  output logic              flag_o,
  output logic [MID_W-1:0]  mid_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic take_new;
  assign take_new = deny_evt && (!flag_o || clear_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      mid_o  <= '0;
      addr_o <= '0;
    end else if (take_new) begin
      flag_o <= 1'b1;
      mid_o  <= deny_mid;
      addr_o <= deny_addr;
    end else if (clear_req) begin
      flag_o <= 1'b0;
    end
  end

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clear_req) |=> flag_o);
  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clear_req) |=> ($stable(mid_o) && $stable(addr_o)));
  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !deny_evt) |=> !flag_o);
  assert_fault_clear_race_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && deny_evt) |=> (flag_o && addr_o == $past(deny_addr)));
endmodule

// File: rtl/bus_firewall.sv
`timescale 1ns/1ps
module bus_firewall #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  open_mode,
  input  logic                                  acc_valid,
  input  logic [MID_W-1:0]                      acc_mid,
  input  logic                                  acc_ns,
  input  logic [ADDR_W-1:0]                     acc_addr,
  input  logic                                  cfg_we,
  input  logic                                  cfg_priv,
  input  logic [1:0]                            cfg_sel,
  input  logic [$clog2(NUM_REGIONS)-1:0]        cfg_idx,
  input  logic [ADDR_W-1:0]                     cfg_wdata,
  output logic                                  dec_valid,
  output logic                                  dec_grant,
  output logic                                  fault_flag,
  output logic [MID_W-1:0]                      fault_mid,
  output logic [ADDR_W-1:0]                     fault_addr
);
  localparam int NUM_MASTERS = 1 << MID_W;
  localparam int IDX_W       = $clog2(NUM_REGIONS);

  logic [NUM_REGIONS-1:0][ADDR_W-1:0]      tbl_base;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0]      tbl_limit;
  logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0] tbl_mask;
  logic [NUM_REGIONS-1:0]                  tbl_secure;
  logic [NUM_REGIONS-1:0]                  tbl_enable;
  logic                                    clear_req;
  logic [NUM_REGIONS-1:0]                  region_match;
  logic                                    any_hit;
  logic                                    policy_allow;
  logic                                    win_secure;
  logic                                    deny_evt;

  fw_region_table #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
    .NUM_MASTERS(NUM_MASTERS), .IDX_W(IDX_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .base_o(tbl_base), .limit_o(tbl_limit), .mask_o(tbl_mask),
    .secure_o(tbl_secure), .enable_o(tbl_enable), .clear_req_o(clear_req)
  );

  fw_match #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W),
    .MID_W(MID_W), .NUM_MASTERS(NUM_MASTERS)
  ) u_match (
    .base_i(tbl_base), .limit_i(tbl_limit), .mask_i(tbl_mask),
    .secure_i(tbl_secure), .enable_i(tbl_enable),
    .addr_i(acc_addr), .mid_i(acc_mid), .ns_i(acc_ns),
    .match_o(region_match), .hit_o(any_hit),
    .allow_o(policy_allow), .win_secure_o(win_secure)
  );

  assign deny_evt = acc_valid && !open_mode && !policy_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_grant <= 1'b0;
    end else begin
      dec_valid <= acc_valid;
      dec_grant <= acc_valid && (open_mode || policy_allow);
    end
  end

  fw_fault_log #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .deny_evt(deny_evt), .deny_mid(acc_mid), .deny_addr(acc_addr),
    .clear_req(clear_req),
    .flag_o(fault_flag), .mid_o(fault_mid), .addr_o(fault_addr)
  );

  assert_decide_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> dec_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!dec_valid && !dec_grant));
  assert_nomatch_deny_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !open_mode && !any_hit) |=> !dec_grant);
  assert_secure_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !open_mode && acc_ns && win_secure) |=> !dec_grant);
  assert_open_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && open_mode) |=> dec_grant);
  assert_deny_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_grant) |-> fault_flag);
endmodule

// File: tb/bus_firewall_tb.sv
`timescale 1ns/1ps
module bus_firewall_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        open_mode = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_mid = '0;
  logic        acc_ns = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_priv = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        dec_valid, dec_grant, fault_flag;
  logic [1:0]  fault_mid;
  logic [31:0] fault_addr;

  always #2 clk = ~clk;

  bus_firewall u_dut (
    .clk(clk), .rst_n(rst_n), .open_mode(open_mode),
    .acc_valid(acc_valid), .acc_mid(acc_mid), .acc_ns(acc_ns), .acc_addr(acc_addr),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .dec_grant(dec_grant),
    .fault_flag(fault_flag), .fault_mid(fault_mid), .fault_addr(fault_addr)
  );

  int vectors = 0;
  int miscompares = 0;

  // bench view of the window table and fault record
  logic [31:0] m_base [8];
  logic [31:0] m_limit[8];
  logic [3:0]  m_mask [8];
  logic        m_sec  [8];
  logic        m_en   [8];
  logic        m_flag = 1'b0;
  logic [1:0]  m_mid  = '0;
  logic [31:0] m_addr = '0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] attr(input logic [3:0] mask, input logic sec, input logic en);
    return {26'd0, en, sec, mask};
  endfunction

  // first enabled window (lowest index) containing the address decides
  function automatic logic model_grant(input logic [1:0] mid, input logic ns,
                                       input logic [31:0] a, input logic opn);
    int found = -1;
    if (opn) return 1'b1;
    for (int k = 0; k < 8 && found < 0; k++)
      if (m_en[k] && a >= m_base[k] && a <= m_limit[k]) found = k;
    if (found < 0) return 1'b0;
    if (m_sec[found] && ns) return 1'b0;
    return m_mask[found][mid];
  endfunction

  task automatic cfg_write(input logic priv, input logic [1:0] sel,
                           input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_sel = sel; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    if (priv) begin
      case (sel)
        2'd0: m_base[idx]  = data;
        2'd1: m_limit[idx] = data;
        2'd2: begin m_mask[idx] = data[3:0]; m_sec[idx] = data[4]; m_en[idx] = data[5]; end
        default: m_flag = 1'b0;
      endcase
    end
  endtask

  task automatic access(input string req, input logic [1:0] mid, input logic ns,
                        input logic [31:0] a, input logic opn);
    logic exp;
    @(negedge clk);
    acc_valid = 1'b1; acc_mid = mid; acc_ns = ns; acc_addr = a; open_mode = opn;
    exp = model_grant(mid, ns, a, opn);
    if (!exp && !m_flag) begin m_flag = 1'b1; m_mid = mid; m_addr = a; end
    @(negedge clk);
    acc_valid = 1'b0; open_mode = 1'b0;
    chk(req, "dec_valid", {31'd0, dec_valid}, 32'd1);
    chk(req, "dec_grant", {31'd0, dec_grant}, {31'd0, exp});
    chk(req, "fault_flag", {31'd0, fault_flag}, {31'd0, m_flag});
    if (m_flag) begin
      chk(req, "fault_mid", {30'd0, fault_mid}, {30'd0, m_mid});
      chk(req, "fault_addr", fault_addr, m_addr);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 8; k++) begin
      m_base[k] = '0; m_limit[k] = '0; m_mask[k] = '0; m_sec[k] = 1'b0; m_en[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "dec_valid", {31'd0, dec_valid}, 32'd0);
    chk("R10", "fault_flag", {31'd0, fault_flag}, 32'd0);
    chk("R10", "fault_addr", fault_addr, 32'd0);
    // R10/R2: empty table denies
    access("R10", 2'd0, 1'b0, 32'h0000_0000, 1'b0);
    cfg_write(1'b1, 2'd3, 3'd0, 32'd0);
    @(negedge clk);
    chk("R9", "fault_flag after clear", {31'd0, fault_flag}, 32'd0);
    // R1: idle cycle after access
    chk("R1", "dec_valid idle", {31'd0, dec_valid}, 32'd0);

    // table: w0 exclusive to master 0, w1 pair {1,2} secure-only overlapping w0,
    // w2 all masters, w3 all masters secure-only
    cfg_write(1'b1, 2'd0, 3'd0, 32'h1000); cfg_write(1'b1, 2'd1, 3'd0, 32'h1FFF);
    cfg_write(1'b1, 2'd2, 3'd0, attr(4'b0001, 1'b0, 1'b1));
    cfg_write(1'b1, 2'd0, 3'd1, 32'h1800); cfg_write(1'b1, 2'd1, 3'd1, 32'h2FFF);
    cfg_write(1'b1, 2'd2, 3'd1, attr(4'b0110, 1'b1, 1'b1));
    cfg_write(1'b1, 2'd0, 3'd2, 32'h4000); cfg_write(1'b1, 2'd1, 3'd2, 32'h4FFF);
    cfg_write(1'b1, 2'd2, 3'd2, attr(4'b1111, 1'b0, 1'b1));
    cfg_write(1'b1, 2'd0, 3'd3, 32'h5000); cfg_write(1'b1, 2'd1, 3'd3, 32'h5FFF);
    cfg_write(1'b1, 2'd2, 3'd3, attr(4'b1111, 1'b1, 1'b1));

    access("R2", 2'd0, 1'b1, 32'h1000, 1'b0);   // exact base
    access("R2", 2'd0, 1'b1, 32'h1FFF, 1'b0);   // exact limit
    access("R2", 2'd2, 1'b0, 32'h3000, 1'b0);   // one past w1 limit: no window, fault set
    access("R8", 2'd3, 1'b0, 32'h6000, 1'b0);   // second denial must not overwrite
    cfg_write(1'b0, 2'd3, 3'd0, 32'd0);         // R9: unprivileged clear ignored
    @(negedge clk);
    chk("R9", "flag after unpriv clear", {31'd0, fault_flag}, 32'd1);
    cfg_write(1'b1, 2'd3, 3'd0, 32'd0);
    access("R3", 2'd1, 1'b0, 32'h1900, 1'b0);   // w0 wins over w1: deny
    access("R3", 2'd1, 1'b0, 32'h2000, 1'b0);   // only w1: grant
    access("R4", 2'd2, 1'b0, 32'h2800, 1'b0);
    access("R4", 2'd3, 1'b0, 32'h2800, 1'b0);
    for (int m = 0; m < 4; m++) access("R4", m[1:0], 1'b1, 32'h4800, 1'b0);
    access("R5", 2'd1, 1'b1, 32'h2000, 1'b0);
    access("R5", 2'd3, 1'b1, 32'h5100, 1'b0);
    access("R5", 2'd3, 1'b0, 32'h5100, 1'b0);
    cfg_write(1'b1, 2'd3, 3'd0, 32'd0);
    access("R6", 2'd3, 1'b1, 32'h9000_0000, 1'b1);
    chk("R6", "no fault in open mode", {31'd0, fault_flag}, 32'd0);
    // R7: unprivileged disable of w2 must not take effect
    cfg_write(1'b0, 2'd2, 3'd2, attr(4'b0000, 1'b0, 1'b0));
    access("R7", 2'd1, 1'b1, 32'h4100, 1'b0);
    cfg_write(1'b1, 2'd2, 3'd2, attr(4'b0001, 1'b0, 1'b1));
    access("R7", 2'd1, 1'b1, 32'h4100, 1'b0);   // now denied, fault set

    // R9: clear and denial in the same cycle: denial wins, new record
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 2'd3;
    acc_valid = 1'b1; acc_mid = 2'd2; acc_ns = 1'b1; acc_addr = 32'h7777;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0; acc_valid = 1'b0;
    m_flag = 1'b1; m_mid = 2'd2; m_addr = 32'h7777;
    chk("R9", "flag race", {31'd0, fault_flag}, 32'd1);
    chk("R9", "mid race", {30'd0, fault_mid}, 32'd2);
    chk("R9", "addr race", fault_addr, 32'h7777);

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 12 == 0) cfg_write(1'b1, 2'd3, 3'd0, 32'd0);
      else access("R4", 2'($urandom), 1'($urandom), 32'h0C00 + ($urandom % 32'h5800),
                  ($urandom % 10) == 0);
    end
    summary();
    $finish;
  end
endmodule